// File: doc/BRIEF.md
# Serial Audio Transmitter (Clock Master)

This block is a stereo serial audio transmitter that also acts as clock master. It divides the system clock down to a bit clock and produces a word-select line. Each 32-bit slot of a 64-bit frame is filled from a single transmit data register, MSB first. Software programs the port through an 18-bit control word, then supplies samples one word at a time.

A data-request flag shows when the transmit register is free for the next sample. Writing when no request is pending is an overflow. Reaching a slot start with a request still pending is an underflow. Both flags stay set until software clears them. An enabled flag in the status word raises the interrupt line.

When software clears the enable bit, the port finishes the frame it is sending. It then parks its outputs and raises the idle flag. Software waits for idle before it treats the port as stopped.

Top module: `serial_audio_tx`

## Requirements
- R1: After reset the status word is dreq=1 (bit 0), idle=1 (bit 1), ovf=0 (bit 2) and unf=0 (bit 3). The bit clock, word select, serial data and interrupt outputs are all 0.
- R2: Control bits [13:11] select a ratio R from the ordered list 1, 2, 4, 8, 16, 6, 12 for codes 0 to 6; code 7 acts as 1. Each bit lasts 2R clock cycles: R cycles with the bit clock low, then R cycles with it high (non-inverted).
- R3: A frame is 64 bits. Word select is low for bits 0 to 31 (left slot) and high for bits 32 to 63 (right slot), and it changes only at bit boundaries.
- R4: Control bits [10:8] select the data length N: codes 0 to 6 give 8, 16, 18, 20, 22, 24 and 32; code 7 gives 32. The word sent is the low N bits of the transmit register, MSB first. With bit [6]=0 it fills the first N slot positions, and the remaining positions are sent as 0.
- R5: With control bit [6]=1 the N data bits occupy the last N positions of the slot, and the leading positions are sent as 0.
- R6: With control bit [7]=1 every slot pattern is sent one bit later. Slot position 0 then carries the last bit of the previous slot's pattern, or 0 for the first slot after a start.
- R7: Control bit [4] inverts the bit clock and bit [5] inverts word select. This applies while running and to the idle levels.
- R8: The port starts only when enable [0], transmit mode [1], bit-clock master [2] and word-select master [3] are all 1. Otherwise it stays idle and its outputs do not toggle.
- R9: Each slot start moves the transmit register into the shifter and sets dreq. A data write while dreq=1 stores the word and clears dreq. A data write while dreq=0 is dropped and sets ovf.
- R10: A slot that starts with dreq=1 sets unf and sends all zeros.
- R11: A status write clears ovf where stat_keep[0]=0 and unf where stat_keep[1]=0. A bit written as 1 leaves its flag unchanged.
- R12: After enable is cleared, the port keeps sending to the end of bit 63 of the current frame. It then sets idle and returns its outputs to their idle levels.
- R13: irq is the OR over the four status flags of flag AND enable. The enables are control bits [14] (dreq), [15] (idle), [16] (ovf) and [17] (unf).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the divider source |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 18 | Control word value |
| stat_we | input | 1 | Status write strobe |
| stat_keep | input | 2 | Per-flag keep bits for the status write: [1] unf, [0] ovf |
| txd_we | input | 1 | Transmit data write strobe |
| txd_wdata | input | 32 | Transmit sample word |
| status | output | 4 | Status flags {unf, ovf, idle, dreq} |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sdo_o | output | 1 | Serial data |

## Verification
The main serialisation is swept over all seven data lengths, both alignments and both delay settings at the fastest divider. Each case uses distinct left and right words, so the checks can tell a wrong pad position from a wrong bit order. They can also tell a lost slot-to-slot carry under delay from a wrong length mask. A second sweep runs every divider code with a fixed format, to separate period errors from data errors. A third sweep runs all four polarity combinations, to catch swapped or missing inversions in both running and idle levels.

Two further patterns withhold the right-slot word and write twice into a full register. They tell the zero-fill and sticky behaviour of underflow apart from the drop-and-flag behaviour of overflow. A start attempt without master or transmit bits confirms that the enable conditions gate the port.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int SLOT_W    = 32;
    localparam int FRAME_W   = 2 * SLOT_W;
    localparam int BIT_IDX_W = $clog2(FRAME_W);
    localparam int POS_W     = $clog2(SLOT_W);
    localparam int LEN_W     = $clog2(SLOT_W) + 1;
    localparam int DIV_W     = 5;
    localparam int CTRL_W    = 18;

    // Serial format, captured when the port starts.
    typedef struct packed {
        logic [2:0] div_sel;   // [13:11]
        logic [2:0] wlen;      // [10:8]
        logic       delay;     // [7]
        logic       right_al;  // [6]
        logic       ws_inv;    // [5]
        logic       sck_inv;   // [4]
    } fmt_t;

    typedef struct packed {
        logic [3:0] ie;        // [17:14] {unf, ovf, idle, dreq}
        fmt_t       fmt;       // [13:4]
        logic       ws_master; // [3]
        logic       sck_master;// [2]
        logic       tx_mode;   // [1]
        logic       enable;    // [0]
    } ctrl_t;

    typedef struct packed {
        logic unf;
        logic ovf;
        logic idle;
        logic dreq;
    } stat_t;

    function automatic logic [DIV_W-1:0] div_ratio(input logic [2:0] sel);
        case (sel)
            3'd0:    div_ratio = DIV_W'(1);
            3'd1:    div_ratio = DIV_W'(2);
            3'd2:    div_ratio = DIV_W'(4);
            3'd3:    div_ratio = DIV_W'(8);
            3'd4:    div_ratio = DIV_W'(16);
            3'd5:    div_ratio = DIV_W'(6);
            3'd6:    div_ratio = DIV_W'(12);
            default: div_ratio = DIV_W'(1);
        endcase
    endfunction

    function automatic logic [LEN_W-1:0] word_bits(input logic [2:0] code);
        case (code)
            3'd0:    word_bits = LEN_W'(8);
            3'd1:    word_bits = LEN_W'(16);
            3'd2:    word_bits = LEN_W'(18);
            3'd3:    word_bits = LEN_W'(20);
            3'd4:    word_bits = LEN_W'(22);
            3'd5:    word_bits = LEN_W'(24);
            default: word_bits = LEN_W'(SLOT_W);
        endcase
    endfunction

    // Place the low N bits of a sample inside a slot; bit SLOT_W-1 goes out first.
    function automatic logic [SLOT_W-1:0] slot_pattern(input logic [SLOT_W-1:0] d,
                                                       input logic [2:0] code,
                                                       input logic right);
        logic [LEN_W-1:0]  n;
        logic [SLOT_W-1:0] mask;
        logic [SLOT_W-1:0] w;
        n    = word_bits(code);
        mask = (n >= LEN_W'(SLOT_W)) ? '1 : ((SLOT_W'(1) << n) - SLOT_W'(1));
        w    = d & mask;
        slot_pattern = right ? w : (w << (LEN_W'(SLOT_W) - n));
    endfunction

endpackage

// File: rtl/sat_clkgen.sv
module sat_clkgen
    import sat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             phase,
    output logic             bit_end
);
    logic [DIV_W-1:0] hcnt;
    logic             half_end;

    assign half_end = (hcnt == ratio - DIV_W'(1));
    assign bit_end  = run && phase && half_end;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            hcnt  <= '0;
            phase <= 1'b0;
        end else if (half_end) begin
            hcnt  <= '0;
            phase <= ~phase;
        end else begin
            hcnt  <= hcnt + DIV_W'(1);
        end
    end

    // R2: each half bit spans exactly ratio cycles
    assert_half_len_R2: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (phase != $past(phase))) |-> ($past(hcnt) == $past(ratio) - DIV_W'(1)));

endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
    import sat_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic                 bit_end,
    output logic                 run,
    output logic [BIT_IDX_W-1:0] bitn,
    output logic                 start,
    output logic                 load
);
    logic slot_last;
    logic frame_last;

    assign slot_last  = (bitn[POS_W-1:0] == '1);
    assign frame_last = (bitn == '1);
    assign start      = !run && go;
    assign load       = start || (bit_end && slot_last && !(frame_last && !go));

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            bitn <= '0;
        end else if (start) begin
            run  <= 1'b1;
            bitn <= '0;
        end else if (bit_end) begin
            if (frame_last && !go)
                run <= 1'b0;
            bitn <= bitn + BIT_IDX_W'(1);
        end
    end

    // R12: the port only stops after the last bit of a frame
    assert_stop_at_frame_R12: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> ($past(bitn) == BIT_IDX_W'(FRAME_W - 1)));

    // R9: a new word enters the shifter only at slot position 0
    assert_load_at_slot_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> (run && bitn[POS_W-1:0] == '0));

endmodule

// File: rtl/sat_shifter.sv
module sat_shifter
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              load,
    input  logic              bit_end,
    input  logic              wr,
    input  logic [SLOT_W-1:0] wdata,
    input  logic [2:0]        wlen,
    input  logic              right_al,
    input  logic              clr_ovf,
    input  logic              clr_unf,
    output logic              dreq,
    output logic              ovf,
    output logic              unf,
    output logic              bit_now,
    output logic              bit_prev
);
    logic [SLOT_W-1:0] hold;
    logic [SLOT_W-1:0] shreg;
    logic              starve;
    logic [SLOT_W-1:0] pick;

    // A write landing together with a load goes straight to the shifter.
    assign starve   = dreq && !wr;
    assign pick     = (wr && dreq) ? wdata : hold;
    assign bit_now  = shreg[SLOT_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hold     <= '0;
            shreg    <= '0;
            bit_prev <= 1'b0;
            dreq     <= 1'b1;
            ovf      <= 1'b0;
            unf      <= 1'b0;
        end else begin
            if (wr && dreq)
                hold <= wdata;

            if (load)
                dreq <= 1'b1;
            else if (wr && dreq)
                dreq <= 1'b0;

            if (wr && !dreq)
                ovf <= 1'b1;
            else if (clr_ovf)
                ovf <= 1'b0;

            if (load && starve)
                unf <= 1'b1;
            else if (clr_unf)
                unf <= 1'b0;

            if (load) begin
                shreg    <= starve ? '0 : slot_pattern(pick, wlen, right_al);
                bit_prev <= run ? shreg[SLOT_W-1] : 1'b0;
            end else if (bit_end) begin
                shreg    <= shreg << 1;
                bit_prev <= shreg[SLOT_W-1];
            end
        end
    end

    // R10: a starved slot flags underflow and sends zeros
    assert_underflow_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (load && starve) |=> (unf && shreg == '0));

    // R9: every slot start re-arms the data request
    assert_load_sets_dreq_R9: assert property (@(posedge clk) disable iff (rst)
        load |=> dreq);

    // R9: a write into a full register leaves the stored word untouched
    assert_ovf_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (wr && !dreq) |=> $stable(hold));

    // R11: overflow stays set until cleared by a status write
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr_ovf) |=> ovf);

endmodule

// File: rtl/serial_audio_tx.sv
module serial_audio_tx
    import sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              stat_we,
    input  logic [1:0]        stat_keep,
    input  logic              txd_we,
    input  logic [SLOT_W-1:0] txd_wdata,
    output logic [3:0]        status,
    output logic              irq,
    output logic              sck_o,
    output logic              ws_o,
    output logic              sdo_o
);
    ctrl_t                ctrl_q;
    fmt_t                 fmt_q;
    fmt_t                 fmt_use;
    logic                 go;
    logic                 run;
    logic                 start;
    logic                 load;
    logic                 phase;
    logic                 bit_end;
    logic [BIT_IDX_W-1:0] bitn;
    logic                 dreq, ovf, unf;
    logic                 bit_now, bit_prev;
    stat_t                st;

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (ctrl_we)
            ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    assign go = ctrl_q.enable && ctrl_q.tx_mode && ctrl_q.sck_master && ctrl_q.ws_master;

    always_ff @(posedge clk) begin
        if (rst)
            fmt_q <= '0;
        else if (start)
            fmt_q <= ctrl_q.fmt;
    end

    assign fmt_use = start ? ctrl_q.fmt : fmt_q;

    sat_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .ratio   (div_ratio(fmt_use.div_sel)),
        .phase   (phase),
        .bit_end (bit_end)
    );

    sat_frame_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .bit_end (bit_end),
        .run     (run),
        .bitn    (bitn),
        .start   (start),
        .load    (load)
    );

    sat_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .load     (load),
        .bit_end  (bit_end),
        .wr       (txd_we),
        .wdata    (txd_wdata),
        .wlen     (fmt_use.wlen),
        .right_al (fmt_use.right_al),
        .clr_ovf  (stat_we && !stat_keep[0]),
        .clr_unf  (stat_we && !stat_keep[1]),
        .dreq     (dreq),
        .ovf      (ovf),
        .unf      (unf),
        .bit_now  (bit_now),
        .bit_prev (bit_prev)
    );

    assign st.unf  = unf;
    assign st.ovf  = ovf;
    assign st.idle = !run;
    assign st.dreq = dreq;
    assign status  = st;
    assign irq     = |(st & ctrl_q.ie);

    assign sck_o = run ? (phase ^ fmt_q.sck_inv) : ctrl_q.fmt.sck_inv;
    assign ws_o  = run ? (bitn[BIT_IDX_W-1] ^ fmt_q.ws_inv) : ctrl_q.fmt.ws_inv;
    assign sdo_o = run && (fmt_q.delay ? bit_prev : bit_now);

    // R3: word select moves only at bit boundaries while running
    assert_ws_on_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$past(bit_end)) |-> $stable(ws_o));

    // R8: the port cannot leave idle unless all start conditions hold
    assert_start_gated_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> $past(go));

endmodule

// File: tb/serial_audio_tx_tb_top.sv
module serial_audio_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [17:0] ctrl_wdata = '0;
    logic        stat_we = 1'b0;
    logic [1:0]  stat_keep = '0;
    logic        txd_we = 1'b0;
    logic [31:0] txd_wdata = '0;
    logic [3:0]  status;
    logic        irq, sck_o, ws_o, sdo_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    serial_audio_tx dut_i (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .stat_we(stat_we), .stat_keep(stat_keep), .txd_we(txd_we), .txd_wdata(txd_wdata),
        .status(status), .irq(irq), .sck_o(sck_o), .ws_o(ws_o), .sdo_o(sdo_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int ratio_of(input int sel);
        int tbl[7] = '{1, 2, 4, 8, 16, 6, 12};
        return (sel < 7) ? tbl[sel] : 1;
    endfunction

    function automatic int len_of(input int code);
        int tbl[7] = '{8, 16, 18, 20, 22, 24, 32};
        return (code < 7) ? tbl[code] : 32;
    endfunction

    function automatic logic [31:0] pat_of(input logic [31:0] d, input int n, input bit right);
        logic [31:0] p = '0;
        for (int i = 0; i < n; i++)
            p[right ? i : (32 - n + i)] = d[i];
        return p;
    endfunction

    task automatic wr_ctrl(input logic [17:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic wr_txd(input logic [31:0] v);
        @(negedge clk); txd_we = 1'b1; txd_wdata = v;
        @(negedge clk); txd_we = 1'b0;
    endtask

    task automatic wr_stat(input logic [1:0] keep);
        @(negedge clk); stat_we = 1'b1; stat_keep = keep;
        @(negedge clk); stat_we = 1'b0;
    endtask

    // One frame with the given format; left word wl, right word wr_ (if sent).
    task automatic run_frame(input int div, input int wlen, input bit right, input bit dly,
                             input bit sinv, input bit winv, input logic [3:0] ie,
                             input logic [31:0] wl, input logic [31:0] wr_,
                             input bit send_r, input bit dbl, input string tag);
        logic [17:0] ctl;
        logic [31:0] pl, pr;
        bit          cap_d[64];
        bit          cap_w[64];
        int          rises = 0, last = 0, period = 0, bad_d = 0, bad_w = 0;
        bit          prev_s, s, rsent = 1'b0, stopped = 1'b0, idle_early = 1'b0;
        int          n;
        ctl = 18'hF | (18'(sinv) << 4) | (18'(winv) << 5) | (18'(right) << 6) | (18'(dly) << 7)
            | (18'(wlen) << 8) | (18'(div) << 11) | (18'(ie) << 14);
        n  = len_of(wlen);
        pl = pat_of(wl, n, right);
        pr = send_r ? pat_of(wr_, n, right) : 32'h0;
        wr_txd(wl);
        if (dbl) wr_txd(32'hDEAD_BEEF);
        wr_ctrl(ctl);
        prev_s = sck_o ^ sinv;
        for (int t = 0; t < 6000 && !(rises >= 64 && status[1]); t++) begin
            @(negedge clk);
            txd_we = 1'b0; ctrl_we = 1'b0;
            s = sck_o ^ sinv;
            if (s && !prev_s) begin
                if (rises < 64) begin
                    cap_d[rises] = sdo_o;
                    cap_w[rises] = ws_o;
                end
                if (rises == 1) period = t - last;
                last = t;
                rises++;
            end
            prev_s = s;
            if (status[1] && rises < 64) idle_early = 1'b1;
            if (send_r && !rsent && status[0]) begin
                txd_we = 1'b1; txd_wdata = wr_; rsent = 1'b1;
            end
            if (rises == 41 && !stopped) begin
                ctrl_we = 1'b1; ctrl_wdata = ctl & ~18'h1; stopped = 1'b1;
            end
        end
        @(negedge clk); txd_we = 1'b0; ctrl_we = 1'b0;
        for (int k = 0; k < 64; k++) begin
            int  sl = k / 32;
            int  p  = k % 32;
            logic [31:0] ps = sl ? pr : pl;
            bit  e;
            if (dly) e = (p == 0) ? ((sl == 0) ? 1'b0 : pl[0]) : ps[32 - p];
            else     e = ps[31 - p];
            if (cap_d[k] !== e) bad_d++;
            if (cap_w[k] !== (sl[0] ^ winv)) bad_w++;
        end
        chk(bad_d == 0, right ? "R5" : (dly ? "R6" : "R4"), {tag, " data bits wrong"}, bad_d, 0);
        chk(bad_w == 0, "R3", {tag, " word select wrong"}, bad_w, 0);
        chk(period == 2 * ratio_of(div), "R2", {tag, " bit period"}, period, 2 * ratio_of(div));
        chk(rises == 64 && !idle_early && status[1], "R12", {tag, " stop at frame end"},
            {idle_early, 23'd0, 8'(rises)}, 32'd64);
        chk(sck_o == sinv && ws_o == winv && sdo_o == 1'b0, "R7", {tag, " idle levels"},
            {sck_o, ws_o, sdo_o}, {sinv, winv, 1'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int toggles;
        logic last_sck;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(status == 4'b0011, "R1", "reset status", status, 4'b0011);
        chk({irq, sck_o, ws_o, sdo_o} == 4'b0, "R1", "reset outputs", {irq, sck_o, ws_o, sdo_o}, 0);

        // R8: missing transmit mode or master bit keeps the port idle
        for (int v = 0; v < 2; v++) begin
            wr_ctrl(v == 0 ? 18'hD : 18'hB);
            toggles = 0; last_sck = sck_o;
            for (int t = 0; t < 60; t++) begin
                @(negedge clk);
                if (sck_o != last_sck) toggles++;
                last_sck = sck_o;
            end
            chk(status[1] == 1'b1 && toggles == 0, "R8", "port started without all conditions",
                toggles, 0);
        end
        wr_ctrl(18'h0);

        // Format sweep: all lengths, alignments, delay
        for (int wl = 0; wl < 7; wl++)
            for (int al = 0; al < 2; al++)
                for (int d = 0; d < 2; d++) begin
                    logic [31:0] a = 32'hA5C3_96E1 ^ (32'(wl * 4 + al * 2 + d) * 32'h9E37_79B9);
                    run_frame(0, wl, al[0], d[0], 1'b0, 1'b0, 4'h0, a, {a[15:0], ~a[31:16]},
                              1'b1, 1'b0, "fmt");
                end
        chk(status[3:2] == 2'b00, "R10", "no underflow in refilled frames", status[3:2], 0);

        // Divider sweep
        for (int dv = 0; dv < 8; dv++)
            run_frame(dv, 5, 1'b0, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0012_3456 + 32'(dv),
                      32'h00FE_DCBA, 1'b1, 1'b0, "div");

        // Polarity combinations
        for (int pv = 0; pv < 4; pv++)
            run_frame(1, 1, 1'b0, 1'b1, pv[0], pv[1], 4'h0, 32'h0000_B00F, 32'h0000_7EA1,
                      1'b1, 1'b0, "pol");
        wr_ctrl(18'h0);

        // R9 data request and overflow
        wr_txd(32'h1111_2222);
        chk(status[0] == 1'b0, "R9", "dreq clears on write", status[0], 0);
        wr_txd(32'h3333_4444);
        chk(status[2] == 1'b1, "R9", "overflow on full write", status[2], 1);
        wr_stat(2'b11);
        chk(status[2] == 1'b1, "R11", "keep bit preserves ovf", status[2], 1);
        wr_stat(2'b10);
        chk(status[2] == 1'b0, "R11", "ovf cleared by zero write", status[2], 0);
        // register already holds 1111_2222; run_frame writes wl while full -> dropped
        run_frame(0, 6, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 32'h1111_2222, 32'h5555_6666,
                  1'b1, 1'b1, "ovf");
        chk(status[2] == 1'b1, "R9", "ovf after extra write", status[2], 1);
        wr_stat(2'b00);

        // R10 underflow with irq enable on unf (R13)
        run_frame(0, 6, 1'b0, 1'b0, 1'b0, 1'b0, 4'b1000, 32'hCAFE_F00D, 32'h0,
                  1'b0, 1'b0, "unf");
        chk(status[3] == 1'b1, "R10", "underflow flag", status[3], 1);
        chk(irq == 1'b1, "R13", "irq from unf", irq, 1);
        wr_stat(2'b01);
        chk(status[3] == 1'b0 && irq == 1'b0, "R11", "unf cleared, irq drops", {status[3], irq}, 0);
        wr_ctrl(18'h1 << 14);
        chk(irq == 1'b1, "R13", "irq from dreq", irq, 1);
        wr_ctrl(18'h2 << 14);
        chk(irq == 1'b1, "R13", "irq from idle", irq, 1);
        wr_ctrl(18'h0);
        chk(irq == 1'b0, "R13", "irq masked", irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule